// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits between an on-chip request source and an external 8-bit NAND flash bus, where command, address and data share one byte-wide path. It takes one request at a time through a valid/ready handshake. A request is a page read, a page program, a block erase or a status read. The block turns each request into the required bus phases: a command byte, three address bytes, the data bytes and a closing command. It then waits for the flash to report ready, and reports completion with a one-cycle done pulse.

The widths of the three strobe phases (setup, strobe-low, strobe-high) are counted in system clocks from configuration inputs. The read byte is captured on the clock edge that ends the strobe-low phase, so the strobe-low width also sets the read access delay. The ready/busy line passes through a synchronizer before it is used. Any busy wait, before the first bus cycle of a request or after its closing command, is bounded by a configurable clock limit. If that limit is reached, the request ends with a timeout flag. A two-bit die index selects one of four active-low chip selects. A per-request flag drives the spare-area disable pin. The write-protect pin is released only while a program or an erase is in flight.

Write bytes are pulled from a streaming source with a one-cycle consume pulse. Read bytes leave with a one-cycle valid pulse.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset, and with no request in flight, every chip select is high, write-protect is low, both strobes are high, CLE and ALE are low, the bus is not driven, spare-disable is low and reqReady is high.
- R2: A command byte is written with CLE=1, ALE=0 and the bus driven, and the flash captures it on the rising edge of WE#. The codes are: read 00h; program 80h then 10h; erase 60h then D0h; status 70h. reqOp encodes read=0, program=1, erase=2, status=3.
- R3: Read, program and erase each send exactly three address writes with ALE=1 and CLE=0, in this order: 00h (column), row bits 7:0, row bits 15:8.
- R4: Program writes its data with CLE=ALE=0. It writes 528 bytes when reqSpareOff=0 and 512 bytes when reqSpareOff=1. Each byte is taken from wrData in a cycle where wrReady pulses, once per byte.
- R5: Read returns 528 bytes (reqSpareOff=0) or 512 bytes (reqSpareOff=1). Status returns one byte. Each byte is the value on nandDin at the edge where RE# rises, and is delivered with a one-cycle rdValid. The bus is not driven while RE# is low.
- R6: Every WE# and RE# low pulse lasts exactly cfgLow clocks.
- R7: No WE# or RE# falling edge occurs while R/B# is low. The block waits for ready before the first cycle of a request, and waits for ready again after the closing program or erase command and after the address of a read.
- R8: If a wait exceeds cfgTimeout clocks, the request ends at once with doneValid and doneTimeout both high, and no further bus cycle is issued for that request.
- R9: The chip select for reqDie is the only one low. It stays low from acceptance through the done pulse and is released afterwards.
- R10: Write-protect is high only from acceptance to done of a program or an erase.
- R11: Spare-disable follows reqSpareOff for the duration of a read or program request, and is low otherwise.
- R12: reqReady is high exactly when no request is in flight. Each accepted request produces one single-cycle doneValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqOp | input | 2 | Operation: 0 read, 1 program, 2 erase, 3 status |
| reqDie | input | DIE_W (2) | Die index |
| reqRow | input | ROW_W (16) | Page row address |
| reqSpareOff | input | 1 | Drive spare-disable during the request |
| cfgSetup | input | CNT_W (8) | Clocks from bus setup to strobe fall (0 acts as 1) |
| cfgLow | input | CNT_W (8) | Strobe-low clocks, also the read access delay |
| cfgHigh | input | CNT_W (8) | Strobe-high hold clocks |
| cfgTimeout | input | TO_W (24) | Busy-wait limit in clocks |
| wrData | input | 8 | Next program byte |
| wrReady | output | 1 | Program byte consumed this cycle |
| rdData | output | 8 | Read byte |
| rdValid | output | 1 | rdData valid |
| doneValid | output | 1 | Request finished |
| doneTimeout | output | 1 | Request ended by the busy limit |
| nandDout | output | 8 | Bus value driven to flash |
| nandDoe | output | 1 | Bus output enable |
| nandDin | input | 8 | Bus value from flash |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandCeN | output | DIES (4) | Chip selects, active low |
| nandWpN | output | 1 | Write protect, active low |
| nandSe | output | 1 | Spare-area disable |
| nandRbN | input | 1 | Ready/busy from flash, low when busy |

## Verification
Two events can meet at a request boundary: the done pulse of one request, and the offer of the next request, which the requester holds valid throughout. The bench provokes this by holding reqValid high across the end of one status read, while the die index changes to that of the following request. On every clock it compares chip selects, write-protect, spare-disable and reqReady against a model that tracks acceptance and completion. It checks that the old select is released before the new one is taken and that no two selects are ever low together. A second meeting point is a busy line that is still low when a timed-out request ends. The next request must then wait for ready before its first strobe, and every strobe fall is judged against the R/B# level at that clock.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_ERASE  = 2'd2,
    OP_STATUS = 2'd3
  } nandOp_t;

  typedef enum logic [1:0] {
    CYC_CMD,
    CYC_ADDR,
    CYC_WDATA,
    CYC_RDATA
  } cycKind_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HIGH
  } phase_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_CMD1,
    S_ADDR,
    S_WDATA,
    S_CMD2,
    S_BUSY,
    S_RDATA,
    S_DONE
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     cycStart;
    cycKind_t kind;
    logic [7:0] outByte;
    logic     waitClr;
  } dpStrobe_t;

  localparam logic [7:0] CMD_READ      = 8'h00;
  localparam logic [7:0] CMD_PROG_LOAD = 8'h80;
  localparam logic [7:0] CMD_PROG_GO   = 8'h10;
  localparam logic [7:0] CMD_ERASE_SET = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO  = 8'hD0;
  localparam logic [7:0] CMD_STATUS    = 8'h70;

  function automatic logic [7:0] openingCmd(nandOp_t op);
    case (op)
      OP_READ:  return CMD_READ;
      OP_PROG:  return CMD_PROG_LOAD;
      OP_ERASE: return CMD_ERASE_SET;
      default:  return CMD_STATUS;
    endcase
  endfunction

endpackage

// File: rtl/nbs_rb_sync.sv
module nbs_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rbIn,
  output logic rbReady
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= rbIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign rbReady = chain[STAGES-1];
endmodule

// File: rtl/nbs_dpath.sv
module nbs_dpath
  import nbs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TO_W  = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic [7:0]       nandDin,
  output logic             cycDone,
  output logic [TO_W-1:0]  waitCnt,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic [7:0]       nandDout,
  output logic             nandDoe,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN
);
  phase_t           phase;
  cycKind_t         kindQ;
  logic [CNT_W-1:0] cnt;

  // a zero width is stretched to one clock
  function automatic logic [CNT_W-1:0] loadOf(logic [CNT_W-1:0] w);
    return (w == '0) ? '0 : w - CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      kindQ    <= CYC_CMD;
      cnt      <= '0;
      nandCle  <= 1'b0;
      nandAle  <= 1'b0;
      nandWeN  <= 1'b1;
      nandReN  <= 1'b1;
      nandDout <= '0;
      nandDoe  <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (strobe.cycStart) begin
            kindQ    <= strobe.kind;
            nandCle  <= (strobe.kind == CYC_CMD);
            nandAle  <= (strobe.kind == CYC_ADDR);
            nandDoe  <= (strobe.kind != CYC_RDATA);
            nandDout <= strobe.outByte;
            cnt      <= loadOf(cfgSetup);
            phase    <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_LOW;
            cnt   <= loadOf(cfgLow);
            if (kindQ == CYC_RDATA) nandReN <= 1'b0;
            else                    nandWeN <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            nandWeN <= 1'b1;
            nandReN <= 1'b1;
            if (kindQ == CYC_RDATA) begin
              rdData  <= nandDin;
              rdValid <= 1'b1;
            end
            cnt   <= loadOf(cfgHigh);
            phase <= PH_HIGH;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            phase   <= PH_IDLE;
            nandCle <= 1'b0;
            nandAle <= 1'b0;
            nandDoe <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cycDone = (phase == PH_HIGH) && (cnt == '0);

  // wait counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (strobe.waitClr)  waitCnt <= '0;
    else if (waitCnt != '1)   waitCnt <= waitCnt + TO_W'(1);
  end
endmodule

// File: rtl/nbs_ctrl.sv
module nbs_ctrl
  import nbs_pkg::*;
#(
  parameter int DIES        = 4,
  parameter int DIE_W       = 2,
  parameter int ROW_W       = 16,
  parameter int TO_W        = 24,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int GUARD       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [DIE_W-1:0] reqDie,
  input  logic [ROW_W-1:0] reqRow,
  input  logic             reqSpareOff,
  input  logic [TO_W-1:0]  cfgTimeout,
  input  logic [7:0]       wrData,
  output logic             wrReady,
  output logic             doneValid,
  output logic             doneTimeout,
  input  logic             cycDone,
  input  logic [TO_W-1:0]  waitCnt,
  input  logic             rbReady,
  output dpStrobe_t        strobe,
  output logic [DIES-1:0]  ceN,
  output logic             wpN,
  output logic             se
);
  localparam int FULL_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int LEN_W      = $clog2(FULL_BYTES + 1);

  state_t           state;
  nandOp_t          opQ;
  logic [DIE_W-1:0] dieQ;
  logic [15:0]      rowQ;
  logic             spareQ;
  logic             issued;
  logic [1:0]       addrIdx;
  logic [LEN_W-1:0] byteCnt;
  logic             toQ;

  logic [LEN_W-1:0] pageLast;
  logic [LEN_W-1:0] readLast;
  logic             inIssue;
  logic             readyOk;
  logic             limitHit;

  assign pageLast = spareQ ? LEN_W'(MAIN_BYTES - 1) : LEN_W'(FULL_BYTES - 1);
  assign readLast = (opQ == OP_STATUS) ? '0 : pageLast;
  assign inIssue  = (state == S_CMD1) || (state == S_ADDR) || (state == S_WDATA) ||
                    (state == S_CMD2) || (state == S_RDATA);
  assign readyOk  = rbReady && (waitCnt >= TO_W'(GUARD));
  assign limitHit = waitCnt >= cfgTimeout;

  always_comb begin
    strobe          = '0;
    strobe.kind     = CYC_CMD;
    strobe.cycStart = inIssue && !issued;
    strobe.waitClr  = (state != S_PRE) && (state != S_BUSY);
    case (state)
      S_CMD1: strobe.outByte = openingCmd(opQ);
      S_ADDR: begin
        strobe.kind = CYC_ADDR;
        case (addrIdx)
          2'd1:    strobe.outByte = rowQ[7:0];
          2'd2:    strobe.outByte = rowQ[15:8];
          default: strobe.outByte = 8'h00;
        endcase
      end
      S_WDATA: begin
        strobe.kind    = CYC_WDATA;
        strobe.outByte = wrData;
      end
      S_CMD2:  strobe.outByte = (opQ == OP_PROG) ? CMD_PROG_GO : CMD_ERASE_GO;
      S_RDATA: strobe.kind = CYC_RDATA;
      default: strobe.outByte = 8'h00;
    endcase
  end

  assign wrReady     = (state == S_WDATA) && strobe.cycStart;
  assign reqReady    = (state == S_IDLE);
  assign doneValid   = (state == S_DONE);
  assign doneTimeout = doneValid && toQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opQ     <= OP_READ;
      dieQ    <= '0;
      rowQ    <= '0;
      spareQ  <= 1'b0;
      issued  <= 1'b0;
      addrIdx <= '0;
      byteCnt <= '0;
      toQ     <= 1'b0;
      ceN     <= '1;
      wpN     <= 1'b0;
      se      <= 1'b0;
    end else begin
      if (strobe.cycStart) issued <= 1'b1;
      case (state)
        S_IDLE: begin
          if (reqValid) begin
            opQ     <= nandOp_t'(reqOp);
            dieQ    <= reqDie;
            rowQ    <= 16'(reqRow);
            spareQ  <= reqSpareOff;
            issued  <= 1'b0;
            addrIdx <= '0;
            byteCnt <= '0;
            toQ     <= 1'b0;
            ceN     <= ~(DIES'(1) << reqDie);
            wpN     <= (nandOp_t'(reqOp) == OP_PROG) || (nandOp_t'(reqOp) == OP_ERASE);
            se      <= reqSpareOff &&
                       ((nandOp_t'(reqOp) == OP_READ) || (nandOp_t'(reqOp) == OP_PROG));
            state   <= S_PRE;
          end
        end
        S_PRE: begin
          if (rbReady)       state <= S_CMD1;
          else if (limitHit) begin
            toQ   <= 1'b1;
            state <= S_DONE;
          end
        end
        S_CMD1: if (cycDone) begin
          issued <= 1'b0;
          state  <= (opQ == OP_STATUS) ? S_RDATA : S_ADDR;
        end
        S_ADDR: if (cycDone) begin
          issued  <= 1'b0;
          addrIdx <= addrIdx + 2'd1;
          if (addrIdx == 2'd2) begin
            case (opQ)
              OP_READ: state <= S_BUSY;
              OP_PROG: state <= S_WDATA;
              default: state <= S_CMD2;
            endcase
          end
        end
        S_WDATA: if (cycDone) begin
          issued <= 1'b0;
          if (byteCnt == pageLast) begin
            byteCnt <= '0;
            state   <= S_CMD2;
          end else begin
            byteCnt <= byteCnt + LEN_W'(1);
          end
        end
        S_CMD2: if (cycDone) begin
          issued <= 1'b0;
          state  <= S_BUSY;
        end
        S_BUSY: begin
          if (readyOk) begin
            byteCnt <= '0;
            state   <= (opQ == OP_READ) ? S_RDATA : S_DONE;
          end else if (limitHit) begin
            toQ   <= 1'b1;
            state <= S_DONE;
          end
        end
        S_RDATA: if (cycDone) begin
          issued <= 1'b0;
          if (byteCnt == readLast) state <= S_DONE;
          else byteCnt <= byteCnt + LEN_W'(1);
        end
        S_DONE: begin
          ceN   <= '1;
          wpN   <= 1'b0;
          se    <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int DIES        = 4,
  parameter int ROW_W       = 16,
  parameter int CNT_W       = 8,
  parameter int TO_W        = 24,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int GUARD       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DIE_W      = $clog2(DIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [DIE_W-1:0] reqDie,
  input  logic [ROW_W-1:0] reqRow,
  input  logic             reqSpareOff,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgHigh,
  input  logic [TO_W-1:0]  cfgTimeout,
  input  logic [7:0]       wrData,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             doneValid,
  output logic             doneTimeout,
  output logic [7:0]       nandDout,
  output logic             nandDoe,
  input  logic [7:0]       nandDin,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [DIES-1:0]  nandCeN,
  output logic             nandWpN,
  output logic             nandSe,
  input  logic             nandRbN
);
  dpStrobe_t       strobe;
  logic            cycDone;
  logic [TO_W-1:0] waitCnt;
  logic            rbReady;

  nbs_rb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .rbIn(nandRbN), .rbReady(rbReady)
  );

  nbs_ctrl #(
    .DIES(DIES), .DIE_W(DIE_W), .ROW_W(ROW_W), .TO_W(TO_W),
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES), .GUARD(GUARD)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqDie(reqDie),
    .reqRow(reqRow), .reqSpareOff(reqSpareOff), .cfgTimeout(cfgTimeout),
    .wrData(wrData), .wrReady(wrReady), .doneValid(doneValid),
    .doneTimeout(doneTimeout), .cycDone(cycDone), .waitCnt(waitCnt),
    .rbReady(rbReady), .strobe(strobe), .ceN(nandCeN), .wpN(nandWpN), .se(nandSe)
  );

  nbs_dpath #(.CNT_W(CNT_W), .TO_W(TO_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgSetup(cfgSetup), .cfgLow(cfgLow), .cfgHigh(cfgHigh),
    .nandDin(nandDin), .cycDone(cycDone), .waitCnt(waitCnt),
    .rdData(rdData), .rdValid(rdValid), .nandDout(nandDout), .nandDoe(nandDoe),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN)
  );
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int DIES = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqReady,
  input logic            doneValid,
  input logic            doneTimeout,
  input logic            nandDoe,
  input logic            nandCle,
  input logic            nandAle,
  input logic            nandWeN,
  input logic            nandReN,
  input logic [DIES-1:0] nandCeN,
  input logic            nandWpN,
  input logic            rbReady
);
  a_r9_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~nandCeN));

  a_r10_wp_inside_request: assert property (@(posedge clk) disable iff (!rstN)
    nandWpN |-> (~nandCeN != '0));

  a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  a_r5_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  a_r4_write_drives_bus: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> nandDoe);

  a_r5_read_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDoe);

  a_r7_strobe_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nandWeN) || $fell(nandReN)) |-> rbReady);

  a_r12_idle_no_select: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (~nandCeN == '0));

  a_r8_timeout_with_done: assert property (@(posedge clk) disable iff (!rstN)
    doneTimeout |-> doneValid);

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
endmodule

bind nand_bus_seq nbs_checker #(.DIES(DIES)) i_nbs_checker (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .doneValid(doneValid),
  .doneTimeout(doneTimeout), .nandDoe(nandDoe), .nandCle(nandCle),
  .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
  .nandCeN(nandCeN), .nandWpN(nandWpN), .rbReady(rbReady)
);

// File: tb/test_nand_bus_seq.sv
module test_nand_bus_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [1:0]  reqDie = 2'd0;
  logic [15:0] reqRow = 16'd0;
  logic        reqSpareOff = 1'b0;
  logic [7:0]  cfgSetup = 8'd1, cfgLow = 8'd2, cfgHigh = 8'd1;
  logic [23:0] cfgTimeout = 24'd300;
  logic [7:0]  wrData;
  logic        wrReady;
  logic [7:0]  rdData;
  logic        rdValid, doneValid, doneTimeout;
  logic [7:0]  nandDout;
  logic        nandDoe;
  logic [7:0]  nandDin = 8'h00;
  logic        nandCle, nandAle, nandWeN, nandReN;
  logic [3:0]  nandCeN;
  logic        nandWpN, nandSe;
  logic        nandRbN = 1'b1;

  always #5 clk = ~clk;

  nand_bus_seq i_nand_bus_seq (.*);

  int checks = 0;
  int errors = 0;
  logic [9:0] evQ[$];
  logic [9:0] expQ[$];
  logic [7:0] rdQ[$];
  int  busyLen = 20;
  int  busyCnt = 0;
  int  weLow = 0, reLow = 0;
  logic prevWe = 1'b1, prevRe = 1'b1;
  logic [7:0] lastCmd = 8'hFF;
  int  addrIdx = 0;
  logic [15:0] mRow = 16'd0;
  int  rdIdx = 0;
  bit  mStatus = 0;
  int  wrCnt = 0;
  bit  wrInc = 0;
  bit  active = 0, acceptNext = 0, doneLast = 0;
  logic [1:0] actDie, nextDie;
  logic [1:0] actOp, nextOp;
  bit  actSpare, nextSpare;
  bit  lastTo;

  function automatic logic [7:0] wrPat(int i);
    return 8'(i * 3 + 1);
  endfunction

  function automatic logic [7:0] rdPat(logic [15:0] row, int i);
    return 8'(row[7:0] + row[15:8] + i * 7);
  endfunction

  assign wrData = wrPat(wrCnt);

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural flash model and per-clock reference compare
  always @(negedge clk) begin
    if (rstN) begin
      if (acceptNext) begin
        active = 1; actDie = nextDie; actOp = nextOp; actSpare = nextSpare;
      end
      if (doneLast) active = 0;
      check(nandCeN === (active ? ~(4'b1 << actDie) : 4'hF), "R9", "chip selects",
            int'(nandCeN), active ? int'(~(4'b1 << actDie)) : 15);
      check(nandWpN === (active && (actOp == 2'd1 || actOp == 2'd2)), "R10", "write protect",
            int'(nandWpN), int'(active && (actOp == 2'd1 || actOp == 2'd2)));
      check(nandSe === (active && actSpare && (actOp == 2'd0 || actOp == 2'd1)), "R11",
            "spare disable", int'(nandSe), int'(active && actSpare && actOp < 2));
      check(reqReady === !active, "R12", "ready vs in flight", int'(reqReady), int'(!active));
      acceptNext = reqValid && reqReady;
      nextDie = reqDie; nextOp = reqOp; nextSpare = reqSpareOff;
      doneLast = doneValid;

      if ((prevWe && !nandWeN) || (prevRe && !nandReN))
        check(nandRbN === 1'b1, "R7", "strobe fell while busy", int'(nandRbN), 1);
      if (!nandWeN) weLow++;
      if (!nandReN) reLow++;
      if (prevRe && !nandReN) begin
        nandDin = mStatus ? 8'hE0 : rdPat(mRow, rdIdx);
        rdIdx++;
      end
      if (!prevRe && nandReN) begin
        check(reLow == int'(cfgLow), "R6", "RE# low width", reLow, int'(cfgLow));
        reLow = 0;
      end
      if (!prevWe && nandWeN) begin
        check(weLow == int'(cfgLow), "R6", "WE# low width", weLow, int'(cfgLow));
        weLow = 0;
        evQ.push_back({nandCle, nandAle, nandDout});
        if (nandCle) begin
          lastCmd = nandDout;
          addrIdx = 0;
          mStatus = (nandDout == 8'h70);
          if (nandDout == 8'h10 || nandDout == 8'hD0) busyCnt = busyLen;
        end
        if (nandAle) begin
          if (addrIdx == 1) mRow[7:0] = nandDout;
          if (addrIdx == 2) mRow[15:8] = nandDout;
          addrIdx++;
          if (addrIdx == 3 && lastCmd == 8'h00) begin
            busyCnt = busyLen;
            rdIdx = 0;
          end
        end
      end
      if (busyCnt > 0) begin
        nandRbN = 1'b0;
        busyCnt--;
      end else begin
        nandRbN = 1'b1;
      end
      if (rdValid) rdQ.push_back(rdData);
      if (wrInc) wrCnt++;
      wrInc = wrReady;
    end
    prevWe = nandWeN;
    prevRe = nandReN;
  end

  task automatic offer(input logic [1:0] op, input logic [1:0] die,
                       input logic [15:0] row, input bit spare);
    reqOp = op; reqDie = die; reqRow = row; reqSpareOff = spare;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitDone();
    while (!doneValid) @(negedge clk);
    lastTo = doneTimeout;
    @(negedge clk);
  endtask

  task automatic runReq(input logic [1:0] op, input logic [1:0] die,
                        input logic [15:0] row, input bit spare);
    evQ.delete(); rdQ.delete(); wrCnt = 0;
    offer(op, die, row, spare);
    reqValid = 1'b0;
    waitDone();
  endtask

  task automatic cmpEv(string req);
    int bad = -1;
    check(evQ.size() == expQ.size(), req, "bus write count", evQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < evQ.size(); i++)
      if (bad < 0 && evQ[i] !== expQ[i]) bad = i;
    check(bad < 0, req, "bus write content {cle,ale,byte}",
          bad < 0 ? 0 : int'(evQ[bad]), bad < 0 ? 0 : int'(expQ[bad]));
  endtask

  task automatic expHead(logic [7:0] cmd, logic [15:0] row);
    expQ.delete();
    expQ.push_back({2'b10, cmd});
    expQ.push_back({2'b01, 8'h00});
    expQ.push_back({2'b01, row[7:0]});
    expQ.push_back({2'b01, row[15:8]});
  endtask

  task automatic doProgram(logic [1:0] die, logic [15:0] row, bit spare);
    int n = spare ? 512 : 528;
    expHead(8'h80, row);
    for (int i = 0; i < n; i++) expQ.push_back({2'b00, wrPat(i)});
    expQ.push_back({2'b10, 8'h10});
    runReq(2'd1, die, row, spare);
    cmpEv("R4");
    check(wrCnt == n, "R4", "bytes consumed", wrCnt, n);
    check(!lastTo, "R8", "no timeout on program", int'(lastTo), 0);
  endtask

  task automatic doRead(logic [1:0] die, logic [15:0] row, bit spare);
    int n = spare ? 512 : 528;
    int bad = -1;
    expHead(8'h00, row);
    runReq(2'd0, die, row, spare);
    cmpEv("R3");
    check(rdQ.size() == n, "R5", "bytes returned", rdQ.size(), n);
    for (int i = 0; i < n && i < rdQ.size(); i++)
      if (bad < 0 && rdQ[i] !== rdPat(row, i)) bad = i;
    check(bad < 0, "R5", "read byte", bad < 0 ? 0 : int'(rdQ[bad]),
          bad < 0 ? 0 : int'(rdPat(row, bad)));
  endtask

  task automatic doErase(logic [1:0] die, logic [15:0] row, bit expTo);
    expHead(8'h60, row);
    expQ.push_back({2'b10, 8'hD0});
    runReq(2'd2, die, row, 1'b0);
    cmpEv(expTo ? "R8" : "R3");
    check(lastTo == expTo, "R8", "timeout flag", int'(lastTo), int'(expTo));
  endtask

  task automatic doStatus(logic [1:0] die);
    expQ.delete();
    expQ.push_back({2'b10, 8'h70});
    runReq(2'd3, die, 16'h0, 1'b0);
    cmpEv("R2");
    check(rdQ.size() == 1 && rdQ[0] == 8'hE0, "R5", "status byte",
          rdQ.size() > 0 ? int'(rdQ[0]) : -1, 8'hE0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(nandCeN === 4'hF, "R1", "selects", int'(nandCeN), 15);
    check(nandWpN === 1'b0 && nandSe === 1'b0, "R1", "wp/se", int'({nandWpN, nandSe}), 0);
    check(nandWeN === 1'b1 && nandReN === 1'b1, "R1", "strobes",
          int'({nandWeN, nandReN}), 3);
    check(!nandCle && !nandAle && !nandDoe && reqReady, "R1", "latches/bus/ready",
          int'({nandCle, nandAle, nandDoe, reqReady}), 1);
    repeat (4) @(negedge clk);

    doStatus(2'd0);
    doErase(2'd1, 16'h1234, 1'b0);
    doProgram(2'd2, 16'h0005, 1'b0);
    doProgram(2'd3, 16'h00A0, 1'b1);
    doRead(2'd2, 16'h0102, 1'b0);
    doRead(2'd0, 16'h7777, 1'b1);

    // R6 other strobe widths
    cfgSetup = 8'd2; cfgLow = 8'd3; cfgHigh = 8'd2;
    doStatus(2'd1);
    doErase(2'd3, 16'hBEEF, 1'b0);
    cfgSetup = 8'd1; cfgLow = 8'd2; cfgHigh = 8'd1;

    // R8 timeout, then R7 wait for ready before next request
    busyLen = 500;
    doErase(2'd1, 16'h0042, 1'b1);
    check(nandRbN === 1'b0, "R7", "flash still busy after timeout", int'(nandRbN), 0);
    doStatus(2'd0);
    busyLen = 20;

    // R12 back-to-back requests with valid held across done
    evQ.delete(); rdQ.delete();
    expQ.delete();
    expQ.push_back({2'b10, 8'h70});
    expQ.push_back({2'b10, 8'h70});
    offer(2'd3, 2'd1, 16'h0, 1'b0);
    offer(2'd3, 2'd3, 16'h0, 1'b0);
    reqValid = 1'b0;
    waitDone();
    cmpEv("R12");
    check(rdQ.size() == 2, "R12", "two status bytes", rdQ.size(), 2);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule